// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block listens on a two-wire serial bus as a slave and handles the address phase of every transfer. It finds START and STOP conditions, shifts in the first byte after each START and compares that byte's upper seven bits with an address held in an 8-bit configuration register. Optionally it also accepts the all-zero general call address. When the address is accepted it pulls SDA low for the acknowledge clock and reports the kind of transfer in a status code. It then sets a sticky interrupt flag and stretches SCL low until software clears the flag.

Bus inputs are synchronised to the system clock, and all edges are found on the synchronised copies. The outputs are open-drain pull-down requests: a high output means the pin is pulled low. Data bytes after the address are not handled here. After a transfer is released, the unit ignores the bus until the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the configuration register holds 0xFE (own address 0x7F, general call off), `irq_o` is 0, `status_o` is 00, `gc_o` is 0 and neither pull-down output is active.
- R2: A START (SDA falling while SCL is high) begins address capture. A STOP (SDA rising while SCL is high) returns the unit to idle. A repeated START in the middle of a byte restarts the capture from the first bit.
- R3: The own address is configuration bits 7:1 and is compared with bits 7:1 of the first byte (the first bit on the bus is bit 7). On a match `sda_pd_o` holds SDA low through the ninth clock. A mismatch leaves SDA released and does not set the flag.
- R4: Bit 0 of the first byte gives the direction (1 = read). On an own-address match `status_o` becomes 01 for a write and 10 for a read.
- R5: Configuration bit 0 enables the general call. A first byte of 0x00 is then acknowledged, `status_o` becomes 11 and `gc_o` becomes 1. Byte 0x01 (general call read) is never acknowledged. With bit 0 clear, address zero is never acknowledged.
- R6: The flag `irq_o` is set on the falling SCL edge that ends the acknowledge clock. Only `flag_clr_i` clears it; nothing else does, whatever time passes or whatever happens on the bus.
- R7: From the flag being set until it is cleared, `scl_pd_o` holds SCL low. The hold ends in the cycle after the clear. If a clear arrives in the same cycle as a set, the set wins for that cycle.
- R8: A write through `cfg_we_i`/`cfg_data_i` replaces the configuration register. Later address phases use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 8 | Own address in 7:1, general call enable in 0 |
| flag_clr_i | input | 1 | Software clear of the interrupt flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pd_o | output | 1 | Pull SCL low (clock stretch) |
| sda_pd_o | output | 1 | Pull SDA low (acknowledge) |
| irq_o | output | 1 | Sticky address-match flag / interrupt request |
| status_o | output | 2 | 00 none, 01 own write, 10 own read, 11 general call |
| gc_o | output | 1 | Last match was a general call |

## Verification
The flag set at the end of the acknowledge clock and the software clear strobe can fall in the same system clock cycle. The bench provokes this by holding `flag_clr_i` high across the ninth falling SCL edge. It judges the result by counting rising edges of `irq_o`: exactly one new edge must be seen, and the flag and the SCL hold must both be gone immediately afterwards. Random address bytes, directions and configuration writes are mixed with directed cases for reset, repeated START, general call read and a long wait while the flag is held.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_ACK  = 3'd2,
        ST_HOLD = 3'd3,
        ST_SKIP = 3'd4
    } am_state_e;

    typedef enum logic [1:0] {
        CODE_NONE = 2'b00,
        CODE_WR   = 2'b01,
        CODE_RD   = 2'b10,
        CODE_GC   = 2'b11
    } am_code_e;

    localparam logic [7:0] CFG_RESET = 8'hFE;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl;
            sda_prev_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_prev_q;
    assign scl_fall  = ~scl & scl_prev_q;
    assign start_det = scl & scl_prev_q & sda_prev_q & ~sda;
    assign stop_det  = scl & scl_prev_q & ~sda_prev_q & sda;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_data_i,
    input  logic       flag_clr_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pd_o,
    output logic       sda_pd_o,
    output logic       irq_o,
    output logic [1:0] status_o,
    output logic       gc_o
);
    import i2c_am_pkg::*;

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        am_state_e         st;
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              flag;
        am_code_e          code;
        logic              gc;
    } am_regs_t;

    am_regs_t r_q, r_d;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s)
    );
    i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s)
    );
    i2c_am_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    logic             own_hit, gc_hit, dir_rd, flag_set;
    logic [ADDR_W-1:0] rx_addr;

    always_comb begin
        rx_addr = r_q.shreg[BYTE_W-1:1];
        dir_rd  = r_q.shreg[0];
        gc_hit  = (rx_addr == '0) && r_q.cfg[0] && !dir_rd;
        own_hit = (rx_addr != '0) && (rx_addr == r_q.cfg[BYTE_W-1:1]);
    end

    always_comb begin
        r_d      = r_q;
        flag_set = 1'b0;
        if (cfg_we_i) r_d.cfg = cfg_data_i[BYTE_W-1:0];

        if (start_det) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
        end else if (stop_det) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise && r_q.cnt != LAST_BIT) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        if (own_hit || gc_hit) begin
                            r_d.st   = ST_ACK;
                            r_d.gc   = gc_hit;
                            r_d.code = gc_hit ? CODE_GC : (dir_rd ? CODE_RD : CODE_WR);
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.st   = ST_HOLD;
                        flag_set = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!r_q.flag) r_d.st = ST_SKIP;
                end
                default: ;
            endcase
        end

        if (flag_set)        r_d.flag = 1'b1;
        else if (flag_clr_i) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cfg   <= CFG_RESET[BYTE_W-1:0];
            r_q.shreg <= '0;
            r_q.cnt   <= '0;
            r_q.flag  <= 1'b0;
            r_q.code  <= CODE_NONE;
            r_q.gc    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pd_o = (r_q.st == ST_ACK);
    assign scl_pd_o = (r_q.st == ST_HOLD) && r_q.flag;
    assign irq_o    = r_q.flag;
    assign status_o = r_q.code;
    assign gc_o     = r_q.gc;
endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       flag_clr_i,
    input logic       scl_pd_o,
    input logic       sda_pd_o,
    input logic       irq_o,
    input logic [1:0] status_o,
    input logic       gc_o
);
    // R6: the flag never drops without a clear request
    a_r6_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !flag_clr_i |=> irq_o);

    // R6: a drop of the flag is always preceded by a clear request
    a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(flag_clr_i));

    // R7: SCL is stretched only while the flag is set
    a_r7_hold_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pd_o |-> irq_o);

    // R3: the acknowledge and the stretch never overlap
    a_r3_ack_not_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_pd_o && scl_pd_o));

    // R4: a fresh flag always comes with a transfer code
    a_r4_code_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> status_o != 2'b00);

    // R5: the general call indicator agrees with the code
    a_r5_gc_code: assert property (@(posedge clk) disable iff (!rst_n)
        gc_o |-> status_o == 2'b11);
endmodule

bind i2c_addr_match i2c_am_checker u_chk (
    .clk(clk), .rst_n(rst_n), .flag_clr_i(flag_clr_i),
    .scl_pd_o(scl_pd_o), .sda_pd_o(sda_pd_o), .irq_o(irq_o),
    .status_o(status_o), .gc_o(gc_o)
);

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic flag_clr = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_pd, sda_pd, irq, gc;
    logic [1:0] status;
    wire scl_line = m_scl & ~scl_pd;
    wire sda_line = m_sda & ~sda_pd;

    int checks = 0, failures = 0, cycles = 0, irq_rises = 0;
    logic irq_prev = 1'b0;
    logic [7:0] cfg_model = 8'hFE;

    always #5 clk = ~clk;

    i2c_addr_match dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
        .flag_clr_i(flag_clr), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pd_o(scl_pd), .sda_pd_o(sda_pd), .irq_o(irq),
        .status_o(status), .gc_o(gc)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        irq_prev <= irq;
        if (irq && !irq_prev) irq_rises <= irq_rises + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [1:0] exp_code(input logic [7:0] c, input logic [7:0] b);
        if (b[7:1] == 7'd0) return (c[0] && !b[0]) ? 2'b11 : 2'b00;
        if (b[7:1] == c[7:1]) return b[0] ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        cfg_data = v; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
        cfg_model = v;
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; cyc(H);
        m_scl = 1'b1; wait (scl_line); cyc(H);
        m_scl = 1'b0; cyc(H);
    endtask

    task automatic do_start();
        m_sda = 1'b1; cyc(H);
        m_scl = 1'b1; wait (scl_line); cyc(H);
        m_sda = 1'b0; cyc(H);
        m_scl = 1'b0; cyc(H);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; cyc(H);
        m_scl = 1'b1; wait (scl_line); cyc(H);
        m_sda = 1'b1; cyc(H);
    endtask

    // address byte and ninth clock; returns the acknowledge seen on SDA
    task automatic addr_byte(input logic [7:0] b, input bit clr_hold, output bit ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_sda = 1'b1; cyc(H);
        m_scl = 1'b1; wait (scl_line); cyc(H / 2);
        ack = !sda_line;
        cyc(H / 2);
        if (clr_hold) flag_clr = 1'b1;
        m_scl = 1'b0; cyc(H);
        flag_clr = 1'b0;
        cyc(1);
    endtask

    task automatic release_flag();
        flag_clr = 1'b1; cyc(1);
        flag_clr = 1'b0; cyc(1);
    endtask

    task automatic transfer(input logic [7:0] b, input string tag);
        bit ack;
        logic [1:0] e;
        e = exp_code(cfg_model, b);
        do_start();
        addr_byte(b, 1'b0, ack);
        chk(ack == (e != 2'b00), {tag, " R3 ack"}, ack, e != 2'b00);
        chk(irq == (e != 2'b00), {tag, " R6 flag"}, irq, e != 2'b00);
        if (e != 2'b00) begin
            chk(status == e, {tag, " R4 code"}, status, e);
            chk(gc == (e == 2'b11), {tag, " R5 gc"}, gc, e == 2'b11);
            chk(scl_pd == 1'b1, {tag, " R7 hold"}, scl_pd, 1);
            release_flag();
            chk(irq == 1'b0 && scl_pd == 1'b0, {tag, " R7 release"}, {irq, scl_pd}, 0);
        end else begin
            chk(scl_pd == 1'b0, {tag, " R3 no hold"}, scl_pd, 0);
        end
        do_stop();
    endtask

    initial begin
        bit ack;
        int rises0;
        void'($urandom(32'd4711));
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk(irq == 0 && status == 0 && gc == 0 && scl_pd == 0 && sda_pd == 0,
            "R1 reset outputs", {irq, status, gc, scl_pd, sda_pd}, 0);
        // R1 reset address 0x7F write accepted, general call rejected
        transfer(8'hFE, "R1 reset addr");
        transfer(8'h00, "R1 gc off");

        // R8 new address, read and write
        write_cfg(8'h5A);
        transfer(8'h5A, "R8 write");
        transfer(8'h5B, "R8 read");
        transfer(8'hFE, "R8 old addr");

        // R5 general call enabled: write accepted, read refused
        write_cfg(8'h5B);
        transfer(8'h00, "R5 gc write");
        transfer(8'h01, "R5 gc read");

        // R2 repeated start mid-byte restarts capture
        do_start();
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        do_start();
        addr_byte(8'h5A, 1'b0, ack);
        chk(ack == 1 && status == 2'b01, "R2 repeated start", {ack, status}, 3'b101);
        // R6 flag survives a long wait; R7 SCL held throughout
        cyc(400);
        chk(irq == 1 && scl_pd == 1, "R6 flag held", {irq, scl_pd}, 3);
        release_flag();
        do_stop();
        // R2 after STOP the unit is idle: no pull-downs
        chk(sda_pd == 0 && scl_pd == 0, "R2 idle after stop", {sda_pd, scl_pd}, 0);

        // R7 clear coinciding with set: set wins one cycle, then cleared
        rises0 = irq_rises;
        do_start();
        addr_byte(8'h5A, 1'b1, ack);
        chk(irq_rises == rises0 + 1, "R7 collision set seen", irq_rises - rises0, 1);
        chk(irq == 0 && scl_pd == 0, "R7 collision cleared", {irq, scl_pd}, 0);
        do_stop();

        // random mix
        for (int n = 0; n < 24; n++) begin
            int sel;
            logic [7:0] b;
            if ($urandom % 4 == 0) write_cfg(8'($urandom));
            sel = int'($urandom % 4);
            case (sel)
                0: b = {cfg_model[7:1], 1'($urandom)};
                1: b = {7'd0, 1'($urandom)};
                default: b = 8'($urandom);
            endcase
            transfer(b, "R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule